// File: doc/BRIEF.md
# Bit-Serial PHY Register Write Engine

This block loads a value of up to eight bits into an internal PHY register space one bit at a time. Software-visible width does not matter to the PHY. The only way in is a single 32-bit control register. That register carries an 8-bit bit-address field in bits [15:8], one data bit at bit 7, and a strobe bit for each port at bit 2 × port. For every bit, the engine points the address field at the target PHY bit and places the bit value in the data field. It then pulses the port's strobe high and low again.

A request gives a start bit address, the value, a bit count and a port index, and is issued with a one-cycle start pulse. The engine consumes the value LSB first and increments the bit address after each bit. Every register update is a read-modify-write through a simple register-bus master: one write per clock, with read data reflecting the previous write. Two controller variants are handled. They differ in the control register's offset. The newer variant also needs one all-zero write before the first bit.

Top module: `phy_bb_write_engine`

## Requirements
- R1: While reset is asserted and in the first cycle after it, busy_o, done_o and reg_we_o are low.
- R2: start_i is acted on only while busy_o is low; a start pulse during an operation changes neither the writes issued nor their number.
- R3: A bit count of zero produces done_o high for one cycle, in the cycle after the start edge, with no register write and busy_o staying low.
- R4: With variant_i = 0 every write targets offset 0x04 and there is no clearing write. With variant_i = 1 every write targets offset 0x10, and the first write of an operation is 0x0000_0000.
- R5: Each bit takes four writes in this order: bits [15:8] replaced by the bit address, then bit 7 replaced by the bit value, then the strobe bit set, then the strobe bit cleared.
- R6: Bits are taken from the value LSB first. The bit address starts at bit_addr_i, rises by one per bit, and wraps from 0xFF to 0x00.
- R7: For port_i 0 to 3 the strobe is bit 2 × port_i. For port_i 4 to 7 no strobe bit is touched, and the two strobe writes return the read value unchanged.
- R8: Every write other than the clearing write changes only its target field and keeps every other bit read from the register.
- R9: The bus master issues one write per clock with no gaps. busy_o is high from the start edge through the last write. done_o is high for exactly one cycle, directly after the last write.
- R10: A bit count above 8 is treated as 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle request pulse |
| variant_i | input | 1 | Controller variant: 0 older, 1 newer |
| bit_addr_i | input | 8 | First PHY bit address |
| value_i | input | 8 | Value to write, LSB first |
| count_i | input | 4 | Number of bits (0 to 8, larger clamped) |
| port_i | input | 3 | Port index selecting the strobe bit |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| reg_we_o | output | 1 | Register write strobe |
| reg_addr_o | output | 8 | Register offset |
| reg_wdata_o | output | 32 | Register write data |
| reg_rdata_i | input | 32 | Current register contents |

## Verification
On every cycle the assertions check several things. The completion pulse lasts a single cycle and never overlaps a write. Writes only go to one of the two legal offsets, and the offset holds steady through an operation. Each non-clearing write flips at most one bit outside the address field and touches nothing outside the address, data and strobe fields. The exact order of the four updates, LSB-first consumption with address wrap, the strobe position for each port, clearing on the newer variant, count clamping and the cycle of the done pulse depend on the request. The scoreboard shows them by predicting every write of each scenario.

// File: rtl/phy_bb_pkg.sv
package phy_bb_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRECLR,
    ST_ADDR,
    ST_DATA,
    ST_STB_SET,
    ST_STB_CLR
  } bb_state_e;
endpackage

// File: rtl/phy_bb_variant.sv
module phy_bb_variant #(
  parameter int               BUS_AW  = 8,
  parameter logic [BUS_AW-1:0] OFS_OLD = 8'h04,
  parameter logic [BUS_AW-1:0] OFS_NEW = 8'h10
) (
  input  logic              variant_i,
  output logic [BUS_AW-1:0] ofs_o,
  output logic              preclr_o
);
  assign ofs_o    = variant_i ? OFS_NEW : OFS_OLD;
  assign preclr_o = variant_i;
endmodule

// File: rtl/phy_bb_strobe.sv
module phy_bb_strobe #(
  parameter int BUS_DW     = 32,
  parameter int PORT_W     = 3,
  parameter int NUM_PORTS  = 4,
  parameter int STB_STRIDE = 2
) (
  input  logic [PORT_W-1:0] port_i,
  output logic [BUS_DW-1:0] mask_o
);
  for (genvar g = 0; g < BUS_DW; g++) begin : g_bit
    if ((g % STB_STRIDE == 0) && (g / STB_STRIDE < NUM_PORTS)) begin : g_stb
      assign mask_o[g] = (port_i == PORT_W'(g / STB_STRIDE));
    end else begin : g_none
      assign mask_o[g] = 1'b0;
    end
  end
endmodule

// File: rtl/phy_bb_field.sv
module phy_bb_field
  import phy_bb_pkg::*;
#(
  parameter int BUS_DW    = 32,
  parameter int BADDR_W   = 8,
  parameter int BADDR_LSB = 8,
  parameter int DBIT_POS  = 7
) (
  input  bb_state_e          state_i,
  input  logic [BUS_DW-1:0]  rdata_i,
  input  logic [BADDR_W-1:0] baddr_i,
  input  logic               dbit_i,
  input  logic [BUS_DW-1:0]  stb_mask_i,
  output logic [BUS_DW-1:0]  wdata_o
);
  always_comb begin
    wdata_o = rdata_i;
    unique case (state_i)
      ST_PRECLR:  wdata_o = '0;
      ST_ADDR:    wdata_o[BADDR_LSB +: BADDR_W] = baddr_i;
      ST_DATA:    wdata_o[DBIT_POS] = dbit_i;
      ST_STB_SET: wdata_o = rdata_i | stb_mask_i;
      ST_STB_CLR: wdata_o = rdata_i & ~stb_mask_i;
      default:    wdata_o = rdata_i;
    endcase
  end
endmodule

// File: rtl/phy_bb_seq.sv
module phy_bb_seq
  import phy_bb_pkg::*;
#(
  parameter int VAL_W   = 8,
  parameter int CNT_W   = 4,
  parameter int PORT_W  = 3,
  parameter int BADDR_W = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic               variant_i,
  input  logic               preclr_i,
  input  logic [BADDR_W-1:0] bit_addr_i,
  input  logic [VAL_W-1:0]   value_i,
  input  logic [CNT_W-1:0]   count_i,
  input  logic [PORT_W-1:0]  port_i,
  output bb_state_e          state_o,
  output logic [BADDR_W-1:0] baddr_o,
  output logic               dbit_o,
  output logic [PORT_W-1:0]  port_o,
  output logic               var_o,
  output logic               busy_o,
  output logic               done_o
);
  bb_state_e          state_q;
  logic [BADDR_W-1:0] baddr_q;
  logic [VAL_W-1:0]   val_q;
  logic [CNT_W-1:0]   rem_q;
  logic [PORT_W-1:0]  port_q;
  logic               var_q;
  logic               done_q;
  logic [CNT_W-1:0]   n_req;

  assign n_req = (count_i > CNT_W'(VAL_W)) ? CNT_W'(VAL_W) : count_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      baddr_q <= '0;
      val_q   <= '0;
      rem_q   <= '0;
      port_q  <= '0;
      var_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            var_q   <= variant_i;
            port_q  <= port_i;
            baddr_q <= bit_addr_i;
            val_q   <= value_i;
            rem_q   <= n_req;
            if (n_req == '0) done_q  <= 1'b1;
            else             state_q <= preclr_i ? ST_PRECLR : ST_ADDR;
          end
        end
        ST_PRECLR:  state_q <= ST_ADDR;
        ST_ADDR:    state_q <= ST_DATA;
        ST_DATA:    state_q <= ST_STB_SET;
        ST_STB_SET: state_q <= ST_STB_CLR;
        ST_STB_CLR: begin
          if (rem_q == CNT_W'(1)) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
          end else begin
            rem_q   <= rem_q - CNT_W'(1);
            baddr_q <= baddr_q + BADDR_W'(1);
            val_q   <= val_q >> 1;
            state_q <= ST_ADDR;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign state_o = state_q;
  assign baddr_o = baddr_q;
  assign dbit_o  = val_q[0];
  assign port_o  = port_q;
  assign var_o   = var_q;
  assign busy_o  = (state_q != ST_IDLE);
  assign done_o  = done_q;
endmodule

// File: rtl/phy_bb_write_engine.sv
module phy_bb_write_engine
  import phy_bb_pkg::*;
#(
  parameter int                BUS_AW     = 8,
  parameter int                BUS_DW     = 32,
  parameter int                VAL_W      = 8,
  parameter int                PORT_W     = 3,
  parameter int                NUM_PORTS  = 4,
  parameter int                STB_STRIDE = 2,
  parameter int                BADDR_W    = 8,
  parameter int                BADDR_LSB  = 8,
  parameter int                DBIT_POS   = 7,
  parameter logic [BUS_AW-1:0] OFS_OLD    = 8'h04,
  parameter logic [BUS_AW-1:0] OFS_NEW    = 8'h10,
  localparam int               CNT_W      = $clog2(VAL_W + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic               variant_i,
  input  logic [BADDR_W-1:0] bit_addr_i,
  input  logic [VAL_W-1:0]   value_i,
  input  logic [CNT_W-1:0]   count_i,
  input  logic [PORT_W-1:0]  port_i,
  output logic               busy_o,
  output logic               done_o,
  output logic               reg_we_o,
  output logic [BUS_AW-1:0]  reg_addr_o,
  output logic [BUS_DW-1:0]  reg_wdata_o,
  input  logic [BUS_DW-1:0]  reg_rdata_i
);
  bb_state_e          state;
  logic [BADDR_W-1:0] baddr;
  logic               dbit;
  logic [PORT_W-1:0]  port_held;
  logic               var_held;
  logic               var_sel;
  logic               preclr;
  logic [BUS_DW-1:0]  stb_mask;

  // live request selects variant while idle, latched copy while running
  assign var_sel = busy_o ? var_held : variant_i;

  phy_bb_variant #(
    .BUS_AW (BUS_AW),
    .OFS_OLD(OFS_OLD),
    .OFS_NEW(OFS_NEW)
  ) u_variant (
    .variant_i(var_sel),
    .ofs_o    (reg_addr_o),
    .preclr_o (preclr)
  );

  phy_bb_seq #(
    .VAL_W  (VAL_W),
    .CNT_W  (CNT_W),
    .PORT_W (PORT_W),
    .BADDR_W(BADDR_W)
  ) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .variant_i (variant_i),
    .preclr_i  (preclr),
    .bit_addr_i(bit_addr_i),
    .value_i   (value_i),
    .count_i   (count_i),
    .port_i    (port_i),
    .state_o   (state),
    .baddr_o   (baddr),
    .dbit_o    (dbit),
    .port_o    (port_held),
    .var_o     (var_held),
    .busy_o    (busy_o),
    .done_o    (done_o)
  );

  phy_bb_strobe #(
    .BUS_DW    (BUS_DW),
    .PORT_W    (PORT_W),
    .NUM_PORTS (NUM_PORTS),
    .STB_STRIDE(STB_STRIDE)
  ) u_strobe (
    .port_i(port_held),
    .mask_o(stb_mask)
  );

  phy_bb_field #(
    .BUS_DW   (BUS_DW),
    .BADDR_W  (BADDR_W),
    .BADDR_LSB(BADDR_LSB),
    .DBIT_POS (DBIT_POS)
  ) u_field (
    .state_i   (state),
    .rdata_i   (reg_rdata_i),
    .baddr_i   (baddr),
    .dbit_i    (dbit),
    .stb_mask_i(stb_mask),
    .wdata_o   (reg_wdata_o)
  );

  assign reg_we_o = busy_o;
endmodule

// File: rtl/phy_bb_write_engine_chk.sv
module phy_bb_write_engine_chk #(
  parameter int                BUS_AW     = 8,
  parameter int                BUS_DW     = 32,
  parameter int                NUM_PORTS  = 4,
  parameter int                STB_STRIDE = 2,
  parameter int                BADDR_W    = 8,
  parameter int                BADDR_LSB  = 8,
  parameter int                DBIT_POS   = 7,
  parameter logic [BUS_AW-1:0] OFS_OLD    = 8'h04,
  parameter logic [BUS_AW-1:0] OFS_NEW    = 8'h10
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              busy_o,
  input logic              done_o,
  input logic              reg_we_o,
  input logic [BUS_AW-1:0] reg_addr_o,
  input logic [BUS_DW-1:0] reg_wdata_o,
  input logic [BUS_DW-1:0] reg_rdata_i
);
  function automatic logic [BUS_DW-1:0] stb_all();
    logic [BUS_DW-1:0] m = '0;
    for (int p = 0; p < NUM_PORTS; p++) m[p * STB_STRIDE] = 1'b1;
    return m;
  endfunction

  localparam logic [BUS_DW-1:0] ADDR_MASK = ((BUS_DW'(1) << BADDR_W) - BUS_DW'(1)) << BADDR_LSB;
  localparam logic [BUS_DW-1:0] DBIT_MASK = BUS_DW'(1) << DBIT_POS;
  localparam logic [BUS_DW-1:0] STB_MASK  = stb_all();
  localparam logic [BUS_DW-1:0] LEGAL     = ADDR_MASK | DBIT_MASK | STB_MASK;

  a_r9_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r9_done_after_writes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && !reg_we_o));

  a_r4_offset_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_o |-> (reg_addr_o == OFS_OLD || reg_addr_o == OFS_NEW));

  a_r2_offset_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> $stable(reg_addr_o));

  a_r8_one_bit_outside_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_o && reg_wdata_o != '0) |->
      ($countones((reg_wdata_o ^ reg_rdata_i) & ~ADDR_MASK) <= 1));

  a_r7_fields_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_o && reg_wdata_o != '0) |-> (((reg_wdata_o ^ reg_rdata_i) & ~LEGAL) == '0));
endmodule

bind phy_bb_write_engine phy_bb_write_engine_chk u_chk (.*);

// File: tb/phy_bb_write_engine_bench.sv
module phy_bb_write_engine_bench;
  localparam logic [7:0]  OFS_OLD  = 8'h04;
  localparam logic [7:0]  OFS_NEW  = 8'h10;
  localparam logic [31:0] INIT_OLD = 32'hC3A1_5E2B;
  localparam logic [31:0] INIT_NEW = 32'h7E00_81D4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        variant = 1'b0;
  logic [7:0]  baddr = '0;
  logic [7:0]  value = '0;
  logic [3:0]  count = '0;
  logic [2:0]  port = '0;
  logic        busy, done, we;
  logic [7:0]  addr;
  logic [31:0] wdata, rdata;
  logic [31:0] m_old, m_new;
  logic [31:0] sh_old = INIT_OLD;
  logic [31:0] sh_new = INIT_NEW;

  int n_chk = 0;
  int n_fail = 0;

  logic [7:0]  exp_a[$];
  logic [31:0] exp_d[$];
  string       exp_r[$];

  always #2 clk = ~clk;

  phy_bb_write_engine u_phy_bb_write_engine (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .variant_i(variant),
    .bit_addr_i(baddr), .value_i(value), .count_i(count), .port_i(port),
    .busy_o(busy), .done_o(done), .reg_we_o(we), .reg_addr_o(addr),
    .reg_wdata_o(wdata), .reg_rdata_i(rdata)
  );

  // modelled control registers
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_old <= INIT_OLD;
      m_new <= INIT_NEW;
    end else if (we) begin
      if (addr == OFS_OLD) m_old <= wdata;
      if (addr == OFS_NEW) m_new <= wdata;
    end
  end
  assign rdata = (addr == OFS_OLD) ? m_old : (addr == OFS_NEW) ? m_new : 32'h0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic push(input logic [7:0] a, input logic [31:0] d, input string r);
    exp_a.push_back(a);
    exp_d.push_back(d);
    exp_r.push_back(r);
  endtask

  // monitor: every write popped and compared against the prediction
  always @(negedge clk) begin
    if (rst_n && we) begin
      if (exp_a.size() == 0) begin
        chk(1'b0, "R2/R3", "unexpected write", {24'h0, addr}, 32'h0);
      end else begin
        logic [7:0]  ea;
        logic [31:0] ed;
        string       er;
        ea = exp_a.pop_front();
        ed = exp_d.pop_front();
        er = exp_r.pop_front();
        chk(addr == ea, er, "write offset", {24'h0, addr}, {24'h0, ea});
        chk(wdata == ed, er, "write data", wdata, ed);
      end
    end
  end

  task automatic run_op(input bit v, input logic [7:0] ba, input logic [7:0] val,
                        input logic [3:0] cnt, input logic [2:0] p, input bit interfere);
    logic [31:0] sh;
    logic [7:0]  a;
    logic [7:0]  vv;
    logic [7:0]  ofs;
    int          n;
    int          w;
    int          k;
    sh  = v ? sh_new : sh_old;
    ofs = v ? OFS_NEW : OFS_OLD;
    n   = (cnt > 4'd8) ? 8 : int'(cnt);   // R10 clamp
    w   = 0;
    a   = ba;
    vv  = val;
    if (n > 0 && v) begin
      sh = '0;
      push(ofs, sh, "R4");
      w++;
    end
    for (int i = 0; i < n; i++) begin
      sh[15:8] = a;                        // R5 address field
      push(ofs, sh, "R5");
      sh[7] = vv[0];                       // R6 LSB first
      push(ofs, sh, "R6");
      if (p < 3'd4) sh[2*p] = 1'b1;        // R7 strobe set
      push(ofs, sh, "R7");
      if (p < 3'd4) sh[2*p] = 1'b0;        // R7 strobe clear
      push(ofs, sh, "R7");
      w += 4;
      a  = a + 8'd1;
      vv = vv >> 1;
    end
    if (v) sh_new = sh; else sh_old = sh;

    @(negedge clk);
    start = 1'b1; variant = v; baddr = ba; value = val; count = cnt; port = p;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    if (w == 0) chk(!busy, "R3", "busy on zero count", {31'h0, busy}, 32'h0);
    k = 0;
    while (!done && k < 200) begin
      if (interfere && k == 2) begin
        // R2: second request mid-operation must be ignored
        start = 1'b1; variant = ~v; baddr = 8'h55; value = 8'hFF; count = 4'd3; port = 3'd2;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
      k++;
    end
    start = 1'b0;
    chk(k == w, "R9", "cycles to done", k, w);
    chk(!busy, "R9", "busy with done", {31'h0, busy}, 32'h0);
    @(negedge clk);
    chk(!done, "R9", "done width", {31'h0, done}, 32'h0);
    chk(exp_a.size() == 0, "R9", "missing writes", exp_a.size(), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !done && !we, "R1", "outputs in reset", {29'h0, busy, done, we}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !we, "R1", "outputs after reset", {29'h0, busy, done, we}, 32'h0);

    run_op(1'b0, 8'h0C, 8'h01, 4'd1, 3'd0, 1'b0);  // R4 older, single bit
    run_op(1'b1, 8'h20, 8'h14, 4'd5, 3'd1, 1'b0);  // R4 newer with clearing write
    run_op(1'b1, 8'h2A, 8'h03, 4'd2, 3'd3, 1'b0);  // R7 highest port
    run_op(1'b0, 8'hFE, 8'hA5, 4'd8, 3'd2, 1'b0);  // R6 address wrap
    run_op(1'b0, 8'h40, 8'hFF, 4'd0, 3'd1, 1'b0);  // R3 zero count
    run_op(1'b0, 8'h10, 8'hC3, 4'd12, 3'd1, 1'b0); // R10 clamp
    run_op(1'b0, 8'h33, 8'h02, 4'd2, 3'd5, 1'b0);  // R7 out-of-range port
    run_op(1'b1, 8'h08, 8'h6B, 4'd3, 3'd0, 1'b1);  // R2 start while busy
    run_op(1'b0, 8'h70, 8'h0A, 4'd4, 3'd3, 1'b1);  // R8 keeps older contents

    chk(m_old == sh_old, "R8", "older register final", m_old, sh_old);
    chk(m_new == sh_new, "R8", "newer register final", m_new, sh_new);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule